// File: doc/BRIEF.md
# Guarded 16-bit DSP Arithmetic Unit

A purely combinational arithmetic unit for a 16-bit signed fixed-point datapath. Two operands, a 4-bit operation code and a carry-in enter. A 16-bit result comes out, together with three flags: carry-or-saturation, sign and zero. Each operand is widened by a single guard bit, which is a copy of its bit 15. An operation-specific front end then inverts operands, replaces one of them with a constant of 0, +1 or -1, or picks the carry-in. Every operation shares one guarded adder. The back end picks the final value, clamps it where the operation asks for it, and forms the flags.

The unit handles plain wrap-around add and subtract, and saturating absolute value, negate, increment and decrement. It also provides compare, average, maximum, minimum, the difference of two magnitudes, and the magnitude of a difference. It suits single-step DSP arithmetic. One guard bit cannot hold the growth of a running sum, so the unit is not meant for long accumulation chains.

Top module: `dsp_arith_unit`

## Requirements
- R1: Operation codes: 0 add, 1 subtract, 2 absolute, 3 compare, 4 negate, 5 increment, 6 decrement, 7 average, 8 maximum, 9 minimum, 10 magnitude difference, 11 difference magnitude. Add returns (A + B + cin_i) mod 2^16 with no saturation. carry_sat_o is the unsigned carry out of bit 15.
- R2: Subtract returns (A - B) mod 2^16 with no saturation, and cin_i has no effect. carry_sat_o is 1 exactly when A >= B taken as unsigned values.
- R3: Absolute returns |A| as a signed value. For A = 0x8000 it returns 0x7FFF with carry_sat_o = 1.
- R4: Negate returns -A, increment returns A + 1 and decrement returns A - 1, all saturating. Negate of 0x8000 gives 0x7FFF, increment of 0x7FFF gives 0x7FFF, and decrement of 0x8000 gives 0x8000.
- R5: Compare returns A unchanged on res_o. carry_sat_o is 1 when A >= B unsigned, sign_o is 1 when A < B signed, and zero_o is 1 when A equals B.
- R6: Saturating operations (2, 4, 5, 6, 10, 11) clamp a true result above 32767 to 0x7FFF and below -32768 to 0x8000. For these operations carry_sat_o is 1 exactly when a clamp took place.
- R7: Average returns floor((A + B) / 2) over signed values. It never saturates, and carry_sat_o is 0.
- R8: Maximum returns the signed larger operand and minimum returns the signed smaller one. Both give carry_sat_o = 0.
- R9: Magnitude difference returns |A| - |B| with saturation, where |0x8000| counts as 32768.
- R10: Difference magnitude returns |A - B| computed without intermediate wrap, then saturated to 0x7FFF.
- R11: For every code except compare, sign_o equals res_o[15] and zero_o is 1 exactly when res_o is 0.
- R12: Codes 12 to 15 are unused. They return A on res_o with carry_sat_o = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | 16 | Operand A, two's complement |
| b_i | input | 16 | Operand B, two's complement |
| op_i | input | 4 | Operation code |
| cin_i | input | 1 | Carry-in, used by add only |
| res_o | output | 16 | Result |
| carry_sat_o | output | 1 | Carry-out or saturation event, depending on the operation |
| sign_o | output | 1 | Sign flag |
| zero_o | output | 1 | Zero flag |

## Verification
The embedded checks assume that every input is a known 0 or 1 and that the inputs stay still long enough for the combinational network to settle before it is judged. The bench meets this by changing inputs only on the rising clock edge and reading outputs on the falling edge. It uses fixed vectors plus a sweep over all sixteen codes. The sweep crosses both carry-in values with a set of operands that includes every range extreme, so the clamp, carry and borrow boundaries are all reached.

// File: rtl/dsp_arith_pkg.sv
package dsp_arith_pkg;

    localparam int DW = 16;          // data width
    localparam int GW = DW + 1;      // guarded width
    localparam int OPW = 4;          // operation code width

    typedef enum logic [OPW-1:0] {
        OP_ADD = 4'd0,
        OP_SUB = 4'd1,
        OP_ABS = 4'd2,
        OP_CMP = 4'd3,
        OP_NEG = 4'd4,
        OP_INC = 4'd5,
        OP_DEC = 4'd6,
        OP_AVG = 4'd7,
        OP_MAX = 4'd8,
        OP_MIN = 4'd9,
        OP_DTA = 4'd10,
        OP_ADT = 4'd11
    } op_e;

    // Operands as presented to the shared adder.
    typedef struct packed {
        logic [GW-1:0] x;
        logic [GW-1:0] y;
        logic          cin;
    } addin_t;

    typedef struct packed {
        logic cs;   // carry or saturation
        logic sg;   // sign
        logic zr;   // zero
    } flags_t;

    // Copy bit 15 into the guard position.
    function automatic logic [GW-1:0] gext(input logic [DW-1:0] v);
        return {v[DW-1], v};
    endfunction

    // Magnitude of a guarded value.
    function automatic logic [GW-1:0] gabs(input logic [GW-1:0] v);
        return v[GW-1] ? (~v + {{(GW-1){1'b0}}, 1'b1}) : v;
    endfunction

    // Clamp a guarded value to the data range: returns {clamped, value}.
    function automatic logic [DW:0] sat_fit(input logic [GW-1:0] v);
        logic [DW:0] r;
        if (v[GW-1] != v[DW-1])
            r = {1'b1, v[GW-1] ? {1'b1, {(DW-1){1'b0}}} : {1'b0, {(DW-1){1'b1}}}};
        else
            r = {1'b0, v[DW-1:0]};
        return r;
    endfunction

endpackage

// File: rtl/dsp_arith_pre.sv
module dsp_arith_pre
    import dsp_arith_pkg::*;
(
    input  logic [DW-1:0]  a_i,
    input  logic [DW-1:0]  b_i,
    input  logic [OPW-1:0] op_i,
    input  logic           cin_i,
    output addin_t         add_o
);
    localparam logic [GW-1:0] K_ZERO = '0;
    localparam logic [GW-1:0] K_ONE  = {{(GW-1){1'b0}}, 1'b1};
    localparam logic [GW-1:0] K_MONE = '1;

    logic [GW-1:0] ga, gb;

    assign ga = gext(a_i);
    assign gb = gext(b_i);

    always_comb begin
        add_o.x   = ga;
        add_o.y   = K_ZERO;
        add_o.cin = 1'b0;
        case (op_i)
            OP_ADD: begin
                add_o.y   = gb;
                add_o.cin = cin_i;
            end
            OP_SUB, OP_CMP, OP_MAX, OP_MIN, OP_ADT: begin
                add_o.y   = ~gb;
                add_o.cin = 1'b1;
            end
            OP_ABS: begin
                add_o.x   = a_i[DW-1] ? ~ga : ga;
                add_o.cin = a_i[DW-1];
            end
            OP_NEG: begin
                add_o.x   = ~ga;
                add_o.cin = 1'b1;
            end
            OP_INC: add_o.y = K_ONE;
            OP_DEC: add_o.y = K_MONE;
            OP_AVG: add_o.y = gb;
            OP_DTA: begin
                add_o.x   = gabs(ga);
                add_o.y   = ~gabs(gb);
                add_o.cin = 1'b1;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/dsp_guard_adder.sv
module dsp_guard_adder
    import dsp_arith_pkg::*;
(
    input  addin_t        add_i,
    output logic [GW-1:0] sum_o,
    output logic          c16_o
);
    // The carry-in rides in an extra LSB slot: x gets a 1 appended and y gets
    // cin appended, so bit 0 generates a carry exactly when cin is 1.
    localparam int AW = GW + 1;

    logic [AW-1:0] wide;

    assign wide  = {add_i.x, 1'b1} + {add_i.y, add_i.cin};
    assign sum_o = wide[AW-1:1];
    // Carry into the guard position equals carry out of the data MSB.
    assign c16_o = sum_o[GW-1] ^ add_i.x[GW-1] ^ add_i.y[GW-1];

    always_comb begin
        // R1: the bit-slot adder matches a direct guarded sum
        a_r1_adder_sum: assert (sum_o == add_i.x + add_i.y + {{(GW-1){1'b0}}, add_i.cin})
            else $error("guarded adder sum mismatch");
    end

endmodule

// File: rtl/dsp_arith_post.sv
module dsp_arith_post
    import dsp_arith_pkg::*;
(
    input  logic [DW-1:0]  a_i,
    input  logic [DW-1:0]  b_i,
    input  logic [OPW-1:0] op_i,
    input  logic [GW-1:0]  sum_i,
    input  logic           c16_i,
    output logic [DW-1:0]  res_o,
    output flags_t         flg_o
);
    logic [DW:0] clamp;
    logic        a_lt_b;
    logic        sat_op;

    assign a_lt_b = sum_i[GW-1];
    assign clamp  = (op_i == OP_ADT) ? sat_fit(gabs(sum_i)) : sat_fit(sum_i);
    assign sat_op = (op_i == OP_ABS) || (op_i == OP_NEG) || (op_i == OP_INC) ||
                    (op_i == OP_DEC) || (op_i == OP_DTA) || (op_i == OP_ADT);

    always_comb begin
        res_o     = a_i;
        flg_o.cs  = 1'b0;
        case (op_i)
            OP_ADD, OP_SUB: begin
                res_o    = sum_i[DW-1:0];
                flg_o.cs = c16_i;
            end
            OP_ABS, OP_NEG, OP_INC, OP_DEC, OP_DTA, OP_ADT: begin
                res_o    = clamp[DW-1:0];
                flg_o.cs = clamp[DW];
            end
            OP_AVG: res_o = sum_i[GW-1:1];
            OP_MAX: res_o = a_lt_b ? b_i : a_i;
            OP_MIN: res_o = a_lt_b ? a_i : b_i;
            OP_CMP: flg_o.cs = c16_i;
            default: ;
        endcase
        if (op_i == OP_CMP) begin
            flg_o.sg = a_lt_b;
            flg_o.zr = (sum_i == '0);
        end else begin
            flg_o.sg = res_o[DW-1];
            flg_o.zr = (res_o == '0);
        end
    end

    always_comb begin
        // R3 and R10: magnitudes never come out negative
        if (op_i == OP_ABS || op_i == OP_ADT)
            a_r3_abs_nonneg: assert (res_o[DW-1] == 1'b0) else $error("negative magnitude");
        // R6: a clamp event leaves only a range extreme
        if (sat_op && flg_o.cs)
            a_r6_sat_extreme: assert (res_o == {1'b0, {(DW-1){1'b1}}} || res_o == {1'b1, {(DW-1){1'b0}}})
                else $error("clamp left a non-extreme value");
        // R8: maximum and minimum bound both operands
        if (op_i == OP_MAX)
            a_r8_max_bound: assert ($signed(res_o) >= $signed(a_i) && $signed(res_o) >= $signed(b_i))
                else $error("max below an operand");
        if (op_i == OP_MIN)
            a_r8_min_bound: assert ($signed(res_o) <= $signed(a_i) && $signed(res_o) <= $signed(b_i))
                else $error("min above an operand");
        // R7: average lies between the operands
        if (op_i == OP_AVG)
            a_r7_avg_between: assert (($signed(res_o) >= $signed(a_i) || $signed(res_o) >= $signed(b_i)) &&
                                      ($signed(res_o) <= $signed(a_i) || $signed(res_o) <= $signed(b_i)))
                else $error("average outside operand span");
    end

endmodule

// File: rtl/dsp_arith_unit.sv
module dsp_arith_unit
    import dsp_arith_pkg::*;
(
    input  logic [15:0] a_i,
    input  logic [15:0] b_i,
    input  logic [3:0]  op_i,
    input  logic        cin_i,
    output logic [15:0] res_o,
    output logic        carry_sat_o,
    output logic        sign_o,
    output logic        zero_o
);
    addin_t        add_w;
    logic [GW-1:0] sum_w;
    logic          c16_w;
    flags_t        flg_w;

    dsp_arith_pre u_pre (
        .a_i   (a_i),
        .b_i   (b_i),
        .op_i  (op_i),
        .cin_i (cin_i),
        .add_o (add_w)
    );

    dsp_guard_adder u_add (
        .add_i (add_w),
        .sum_o (sum_w),
        .c16_o (c16_w)
    );

    dsp_arith_post u_post (
        .a_i   (a_i),
        .b_i   (b_i),
        .op_i  (op_i),
        .sum_i (sum_w),
        .c16_i (c16_w),
        .res_o (res_o),
        .flg_o (flg_w)
    );

    assign carry_sat_o = flg_w.cs;
    assign sign_o      = flg_w.sg;
    assign zero_o      = flg_w.zr;

    always_comb begin
        // R12: unused codes pass A through without a carry
        if (op_i > 4'd11)
            a_r12_unused_pass: assert (res_o == a_i && !carry_sat_o) else $error("unused code altered A");
        // R11: sign flag tracks result MSB outside compare
        if (op_i != 4'd3)
            a_r11_sign_msb: assert (sign_o == res_o[15]) else $error("sign flag off result MSB");
    end

endmodule

// File: tb/sim_dsp_arith_unit.sv
module sim_dsp_arith_unit;

    logic        clk = 1'b0;
    logic [15:0] a, b;
    logic [3:0]  op;
    logic        cin;
    logic [15:0] res;
    logic        cs, sg, zr;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    dsp_arith_unit u0 (
        .a_i(a), .b_i(b), .op_i(op), .cin_i(cin),
        .res_o(res), .carry_sat_o(cs), .sign_o(sg), .zero_o(zr)
    );

    // {op, cin, a, b, res, cs, sg, zr}
    localparam int NV = 24;
    localparam logic [55:0] VEC [NV] = '{
        {4'd0,  1'b0, 16'h0003, 16'h0004, 16'h0007, 3'b000},
        {4'd0,  1'b1, 16'hFFFF, 16'h0001, 16'h0001, 3'b100},
        {4'd0,  1'b0, 16'h7FFF, 16'h0001, 16'h8000, 3'b010},
        {4'd1,  1'b1, 16'h0005, 16'h0007, 16'hFFFE, 3'b010},
        {4'd1,  1'b0, 16'h0007, 16'h0005, 16'h0002, 3'b100},
        {4'd2,  1'b0, 16'h8000, 16'h0000, 16'h7FFF, 3'b100},
        {4'd2,  1'b0, 16'hFFFB, 16'h0000, 16'h0005, 3'b000},
        {4'd4,  1'b0, 16'h8000, 16'h0000, 16'h7FFF, 3'b100},
        {4'd4,  1'b0, 16'h0003, 16'h0000, 16'hFFFD, 3'b010},
        {4'd5,  1'b0, 16'h7FFF, 16'h0000, 16'h7FFF, 3'b100},
        {4'd6,  1'b0, 16'h8000, 16'h0000, 16'h8000, 3'b110},
        {4'd6,  1'b0, 16'h0000, 16'h0000, 16'hFFFF, 3'b010},
        {4'd3,  1'b0, 16'h0005, 16'h0005, 16'h0005, 3'b101},
        {4'd3,  1'b0, 16'hFFFF, 16'h0001, 16'hFFFF, 3'b110},
        {4'd7,  1'b0, 16'h7FFF, 16'h7FFF, 16'h7FFF, 3'b000},
        {4'd7,  1'b0, 16'hFFFF, 16'h0000, 16'hFFFF, 3'b010},
        {4'd8,  1'b0, 16'hFFFD, 16'h0002, 16'h0002, 3'b000},
        {4'd9,  1'b0, 16'hFFFD, 16'h0002, 16'hFFFD, 3'b010},
        {4'd10, 1'b0, 16'h8000, 16'h0000, 16'h7FFF, 3'b100},
        {4'd10, 1'b0, 16'h0003, 16'hFFF9, 16'hFFFC, 3'b010},
        {4'd11, 1'b0, 16'h7FFF, 16'h8000, 16'h7FFF, 3'b100},
        {4'd11, 1'b0, 16'h0002, 16'h0009, 16'h0007, 3'b000},
        {4'd12, 1'b0, 16'h0000, 16'h1234, 16'h0000, 3'b001},
        {4'd15, 1'b1, 16'h8001, 16'h0000, 16'h8001, 3'b010}
    };

    function automatic string tag_of(input logic [3:0] o);
        case (o)
            4'd0:  return "R1";
            4'd1:  return "R2";
            4'd2:  return "R3 R6";
            4'd3:  return "R5";
            4'd4, 4'd5, 4'd6: return "R4 R6";
            4'd7:  return "R7";
            4'd8, 4'd9: return "R8";
            4'd10: return "R9 R6";
            4'd11: return "R10 R6";
            default: return "R12";
        endcase
    endfunction

    function automatic int clampv(input int v, output bit hit);
        hit = 1'b0;
        if (v > 32767) begin hit = 1'b1; return 32767; end
        if (v < -32768) begin hit = 1'b1; return -32768; end
        return v;
    endfunction

    function automatic int iabs(input int v);
        return (v < 0) ? -v : v;
    endfunction

    // Reference built from the requirements with integer arithmetic.
    task automatic model(input logic [3:0] o, input logic ci, input logic [15:0] x, input logic [15:0] y,
                         output logic [15:0] r, output logic ec, output logic es, output logic ez);
        int sa, sb, ua, ub, t, v;
        bit hit;
        sa = int'($signed(x));
        sb = int'($signed(y));
        ua = int'({16'd0, x});
        ub = int'({16'd0, y});
        ec = 1'b0;
        r  = x;
        case (o)
            4'd0: begin t = ua + ub + int'(ci); r = t[15:0]; ec = t[16]; end
            4'd1: begin t = ua + (65535 - ub) + 1; r = t[15:0]; ec = t[16]; end
            4'd2: begin v = clampv(iabs(sa), hit); r = v[15:0]; ec = hit; end
            4'd4: begin v = clampv(-sa, hit); r = v[15:0]; ec = hit; end
            4'd5: begin v = clampv(sa + 1, hit); r = v[15:0]; ec = hit; end
            4'd6: begin v = clampv(sa - 1, hit); r = v[15:0]; ec = hit; end
            4'd7: begin v = (sa + sb) >>> 1; r = v[15:0]; end
            4'd8: r = (sa >= sb) ? x : y;
            4'd9: r = (sa <= sb) ? x : y;
            4'd10: begin v = clampv(iabs(sa) - iabs(sb), hit); r = v[15:0]; ec = hit; end
            4'd11: begin v = clampv(iabs(sa - sb), hit); r = v[15:0]; ec = hit; end
            default: ;
        endcase
        if (o == 4'd3) begin
            ec = (ua >= ub);
            es = (sa < sb);
            ez = (sa == sb);
        end else begin
            es = r[15];
            ez = (r == 16'd0);
        end
    endtask

    task automatic check(input string tg, input logic [15:0] er, input logic ec, input logic es, input logic ez);
        checks++;
        if (res !== er || cs !== ec || sg !== es || zr !== ez) begin
            errors++;
            $display("FAIL %s (R11 flags) op=%0d cin=%0b a=%h b=%h: got res=%h cs=%0b sg=%0b zr=%0b, expected res=%h cs=%0b sg=%0b zr=%0b",
                     tg, op, cin, a, b, res, cs, sg, zr, er, ec, es, ez);
        end
    endtask

    task automatic apply(input logic [3:0] o, input logic ci, input logic [15:0] x, input logic [15:0] y);
        @(posedge clk);
        op = o; cin = ci; a = x; b = y;
        @(negedge clk);
    endtask

    localparam int NE = 8;
    localparam logic [15:0] EDGE [NE] = '{16'h0000, 16'h0001, 16'hFFFF, 16'h7FFF,
                                          16'h8000, 16'h7FFE, 16'h8001, 16'h0005};

    initial begin
        logic [15:0] er;
        logic ec, es, ez;
        op = '0; cin = 1'b0; a = '0; b = '0;

        // Fixed vectors covering R1 to R12.
        for (int i = 0; i < NV; i++) begin
            apply(VEC[i][55:52], VEC[i][51], VEC[i][50:35], VEC[i][34:19]);
            check(tag_of(op), VEC[i][18:3], VEC[i][2], VEC[i][1], VEC[i][0]);
        end

        // Sweep: every code, both carry-ins, range extremes (R2 cin has no effect, R6 boundaries).
        for (int o = 0; o < 16; o++) begin
            for (int c = 0; c < 2; c++) begin
                for (int i = 0; i < NE; i++) begin
                    for (int j = 0; j < NE; j++) begin
                        apply(4'(o), 1'(c), EDGE[i], EDGE[j]);
                        model(op, cin, a, b, er, ec, es, ez);
                        check(tag_of(op), er, ec, es, ez);
                    end
                end
            end
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got %0d cycles, expected at most 20000", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule